// File: doc/BRIEF.md
# Embedded Sync Code Decoder

This block sits behind the deserializer of a camera serial link. It receives one byte per byte-clock cycle. Each byte comes with a valid strobe. The block rebuilds frame and line timing from four-byte synchronization codes embedded in the stream. A code is the marker bytes FF, 00, 00 followed by a code byte. The code byte selects start or end of frame, or start or end of line. A vertical sync level and a horizontal sync level are set and cleared from these codes. Every accepted byte is also forwarded, one cycle later, on a parallel data bus with its own valid strobe.

A select input chooses between two modes. In decode mode the sync levels follow the codes. In pass-through mode both sync levels stay low and the matcher is held idle. Every byte, including the bytes of sync codes, still reaches the data bus unchanged. A device enable input powers the block down. While enable is low, every output register is cleared and then held, so nothing toggles. When enable returns, operation restarts from the reset state.

The input stream has a valid/ready pair. The block never applies back-pressure: `in_ready` is always high, and a byte is accepted on every clock edge where `in_valid` is high. The output stream has no ready input. The downstream logic must take each byte in the cycle in which `out_valid` is high.

Top module: `sync_embed_decoder`

## Requirements
- R1: The matcher recognises a code as the accepted byte sequence FF, 00, 00, C. C = 00 is start of line, 01 is end of line, 02 is start of frame and 03 is end of frame. No sync output changes before the byte C is accepted.
- R2: Start of frame (C = 02) drives both `vsync` and `hsync` high.
- R3: End of frame (C = 03) drives both `vsync` and `hsync` low.
- R4: Start of line (C = 00) drives `hsync` high, and end of line (C = 01) drives `hsync` low. In both cases `vsync` keeps its previous value.
- R5: The matcher advances only on cycles where `in_valid` is high. Cycles with `in_valid` low neither advance nor break a partial match.
- R6: While `enable` is low, `out_data`, `out_valid`, `vsync` and `hsync` are all low, whatever the input. The matcher returns to idle, so a partial code seen before power-down does not complete after it.
- R7: While `sync_sel` is low, `vsync` and `hsync` are low and the matcher is idle. Every accepted byte, including the bytes of sync codes, appears unchanged on `out_data`.
- R8: An accepted byte appears on `out_data`, with `out_valid` high, one cycle after acceptance. A sync change also appears one cycle after its code byte is accepted. In a cycle with `in_valid` low, the next `out_valid` is low and `out_data` holds its value.
- R9: A partial match that meets an unexpected byte returns to idle. An FF met inside a partial match restarts the match, so FF FF 00 00 02 is still recognised as start of frame.
- R10: A code byte outside 00 to 03 that follows FF, 00, 00 leaves both sync outputs unchanged.
- R11: `in_ready` is high in every cycle, including during reset and power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Device enable; low powers the block down |
| sync_sel | input | 1 | High: decode sync codes; low: pass-through |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Always high; no back-pressure |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Registered output byte |
| vsync | output | 1 | Vertical sync level |
| hsync | output | 1 | Horizontal sync level |

## Verification
The block is tried with a random stream weighted towards FF, 00 and code bytes. This produces many accidental partial and overlapping codes. All outputs are compared against a reference model at every cycle, which separates correct restart-on-FF handling from a plain shift matcher. Directed sequences test the following:
- the four code types in turn, which shows whether line codes leave `vsync` alone;
- codes broken by valid-low gaps against codes broken by a wrong byte;
- a doubled FF lead;
- out-of-range code bytes.

Pass-through and power-down sequences check that sync codes are forwarded as data without decoding. They also check that a partial code cut by power-down never completes afterwards.

// File: rtl/sed_pkg.sv
package sed_pkg;
  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_LEAD = 2'd1,
    M_Z1   = 2'd2,
    M_Z2   = 2'd3
  } match_st_t;

  typedef enum logic [1:0] {
    C_SOL = 2'd0,
    C_EOL = 2'd1,
    C_SOF = 2'd2,
    C_EOF = 2'd3
  } code_t;
endpackage

// File: rtl/sync_matcher.sv
module sync_matcher
  import sed_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter logic [DATA_W-1:0] LEAD_BYTE = 8'hFF,
  parameter logic [DATA_W-1:0] FILL_BYTE = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              evt_valid,
  output code_t             evt_code
);
  localparam int CODE_W = 2;

  match_st_t st_q, st_d;
  logic is_lead, is_fill, in_range;

  assign is_lead  = (in_data == LEAD_BYTE);
  assign is_fill  = (in_data == FILL_BYTE);
  assign in_range = (in_data[DATA_W-1:CODE_W] == '0);

  always_comb begin
    st_d = st_q;
    if (in_valid) begin
      unique case (st_q)
        M_IDLE: st_d = is_lead ? M_LEAD : M_IDLE;
        M_LEAD: st_d = is_fill ? M_Z1 : (is_lead ? M_LEAD : M_IDLE);
        M_Z1:   st_d = is_fill ? M_Z2 : (is_lead ? M_LEAD : M_IDLE);
        M_Z2:   st_d = is_lead ? M_LEAD : M_IDLE;
        default: st_d = M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= M_IDLE;
    else if (clear) st_q <= M_IDLE;
    else            st_q <= st_d;
  end

  assign evt_valid = !clear && in_valid && (st_q == M_Z2) && in_range;
  assign evt_code  = code_t'(in_data[CODE_W-1:0]);

  // R5: a cycle without a valid byte leaves the matcher where it was
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !in_valid) |=> (st_q == $past(st_q)));

  // R9: a lead byte always (re)starts a match
  a_r9_lead_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && in_valid && is_lead) |=> (st_q == M_LEAD));

  // R6 / R7: a clear forces the matcher idle
  a_r6_clear_idles: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (st_q == M_IDLE));
endmodule

// File: rtl/sync_level_gen.sv
module sync_level_gen
  import sed_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  evt_valid,
  input  code_t evt_code,
  output logic  vsync,
  output logic  hsync
);
  logic v_q, h_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      h_q <= 1'b0;
    end else if (clear) begin
      v_q <= 1'b0;
      h_q <= 1'b0;
    end else if (evt_valid) begin
      unique case (evt_code)
        C_SOF: begin v_q <= 1'b1; h_q <= 1'b1; end
        C_EOF: begin v_q <= 1'b0; h_q <= 1'b0; end
        C_SOL: h_q <= 1'b1;
        C_EOL: h_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign vsync = v_q;
  assign hsync = h_q;

  // R2: start of frame raises both levels
  a_r2_sof_both_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && evt_valid && evt_code == C_SOF) |=> (vsync && hsync));

  // R3: end of frame drops both levels
  a_r3_eof_both_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && evt_valid && evt_code == C_EOF) |=> (!vsync && !hsync));

  // R4: line codes never move the vertical level
  a_r4_line_keeps_v: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && evt_valid && (evt_code == C_SOL || evt_code == C_EOL)) |=> $stable(vsync));

  // R10: without an event the levels hold
  a_r10_no_evt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !evt_valid) |=> ($stable(vsync) && $stable(hsync)));
endmodule

// File: rtl/byte_stage.sv
module byte_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (!enable) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) dat_q <= in_data;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

  // R8: accepted byte appears one cycle later
  a_r8_byte_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && in_valid) |=> (out_valid && out_data == $past(in_data)));

  // R8: idle cycle keeps the data and drops valid
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !in_valid) |=> (!out_valid && $stable(out_data)));
endmodule

// File: rtl/sync_embed_decoder.sv
module sync_embed_decoder
  import sed_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              sync_sel,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              vsync,
  output logic              hsync
);
  localparam logic [DATA_W-1:0] LEAD = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] FILL = {DATA_W{1'b0}};

  logic  sync_clear;
  logic  evt_valid;
  code_t evt_code;

  assign in_ready   = 1'b1;
  assign sync_clear = !enable || !sync_sel;

  sync_matcher #(
    .DATA_W   (DATA_W),
    .LEAD_BYTE(LEAD),
    .FILL_BYTE(FILL)
  ) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (sync_clear),
    .in_valid (in_valid),
    .in_data  (in_data),
    .evt_valid(evt_valid),
    .evt_code (evt_code)
  );

  sync_level_gen u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (sync_clear),
    .evt_valid(evt_valid),
    .evt_code (evt_code),
    .vsync    (vsync),
    .hsync    (hsync)
  );

  byte_stage #(.DATA_W(DATA_W)) u_bytes (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .in_valid (in_valid),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_data (out_data)
  );

  // R6: power-down silences every output
  a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!out_valid && out_data == '0 && !vsync && !hsync));

  // R7: pass-through keeps both sync levels low
  a_r7_bypass_low: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_sel |=> (!vsync && !hsync));

  // R11: never any back-pressure
  a_r11_ready: assert property (@(posedge clk) in_ready);
endmodule

// File: tb/test_sync_embed_decoder.sv
module test_sync_embed_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       sync_sel = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, out_valid, vsync, hsync;
  logic [7:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state
  int         m_st = 0;
  logic       m_v = 0, m_h = 0, m_ov = 0;
  logic [7:0] m_od = 8'h00;

  always #4 clk = ~clk;

  sync_embed_decoder i_sync_embed_decoder (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_sel(sync_sel),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .vsync(vsync), .hsync(hsync)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // next matcher state from requirements R1, R9
  function automatic int next_st(input int st, input logic [7:0] d);
    if (d == 8'hFF) return 1;
    if (d == 8'h00 && (st == 1 || st == 2)) return st + 1;
    return 0;
  endfunction

  task automatic model(input bit en, input bit sel, input bit vld, input logic [7:0] d);
    if (!en) begin
      m_st = 0; m_v = 0; m_h = 0; m_od = 8'h00; m_ov = 0;
    end else begin
      m_ov = vld;
      if (vld) m_od = d;
      if (!sel) begin
        m_st = 0; m_v = 0; m_h = 0;
      end else if (vld) begin
        if (m_st == 3) begin
          case (d)
            8'h02: begin m_v = 1; m_h = 1; end
            8'h03: begin m_v = 0; m_h = 0; end
            8'h00: m_h = 1;
            8'h01: m_h = 0;
            default: ;
          endcase
        end
        m_st = next_st(m_st, d);
      end
    end
  endtask

  task automatic step(input bit en, input bit sel, input bit vld, input logic [7:0] d,
                      input string tag);
    @(negedge clk);
    enable = en; sync_sel = sel; in_valid = vld; in_data = d;
    @(posedge clk);
    model(en, sel, vld, d);
    #2;
    chk({tag, " out_valid"}, 32'(out_valid), 32'(m_ov));
    chk({tag, " out_data"},  32'(out_data),  32'(m_od));
    chk({tag, " vsync"},     32'(vsync),     32'(m_v));
    chk({tag, " hsync"},     32'(hsync),     32'(m_h));
    chk({tag, " in_ready"},  32'(in_ready),  32'd1);
  endtask

  task automatic code(input logic [7:0] c, input string tag);
    step(1, 1, 1, 8'hFF, tag);
    step(1, 1, 1, 8'h00, tag);
    step(1, 1, 1, 8'h00, tag);
    step(1, 1, 1, c, tag);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    #1;
    chk("R6 reset vsync", 32'(vsync), 0);
    chk("R6 reset out_valid", 32'(out_valid), 0);
    chk("R11 ready in reset", 32'(in_ready), 1);
    @(negedge clk); rst_n = 1'b1;

    // R1: no change before code byte, then start of frame
    step(1, 1, 1, 8'hFF, "R1");
    step(1, 1, 1, 8'h00, "R1");
    step(1, 1, 1, 8'h00, "R1");
    chk("R1 before code h", 32'(hsync), 0);
    step(1, 1, 1, 8'h02, "R2");
    chk("R2 sof v", 32'(vsync), 1);
    chk("R2 sof h", 32'(hsync), 1);
    chk("R8 code byte echoed", 32'(out_data), 32'h02);
    code(8'h01, "R4");
    chk("R4 eol h", 32'(hsync), 0);
    chk("R4 eol v kept", 32'(vsync), 1);
    code(8'h00, "R4");
    chk("R4 sol h", 32'(hsync), 1);
    chk("R4 sol v kept", 32'(vsync), 1);
    code(8'h03, "R3");
    chk("R3 eof v", 32'(vsync), 0);
    chk("R3 eof h", 32'(hsync), 0);
    code(8'h00, "R4");
    chk("R4 sol from low v", 32'(vsync), 0);
    chk("R4 sol from low h", 32'(hsync), 1);
    code(8'h01, "R4");

    // R5: idle gaps inside a code
    step(1, 1, 1, 8'hFF, "R5"); step(1, 1, 0, 8'h5A, "R5");
    step(1, 1, 1, 8'h00, "R5"); step(1, 1, 0, 8'h77, "R5");
    step(1, 1, 1, 8'h00, "R5"); step(1, 1, 0, 8'h13, "R5");
    chk("R8 idle drops valid", 32'(out_valid), 0);
    chk("R8 idle holds data", 32'(out_data), 32'h00);
    step(1, 1, 1, 8'h02, "R5");
    chk("R5 gapped sof v", 32'(vsync), 1);
    code(8'h03, "R3");

    // R9: broken and restarted matches
    step(1, 1, 1, 8'hFF, "R9"); step(1, 1, 1, 8'h00, "R9");
    step(1, 1, 1, 8'h5A, "R9"); step(1, 1, 1, 8'h02, "R9");
    chk("R9 broken no sof", 32'(vsync), 0);
    step(1, 1, 1, 8'hFF, "R9");
    code(8'h02, "R9");
    chk("R9 double lead sof", 32'(vsync), 1);
    step(1, 1, 1, 8'hFF, "R9"); step(1, 1, 1, 8'h00, "R9");
    code(8'h03, "R9");
    chk("R9 lead in Z1 eof", 32'(vsync), 0);

    // R10: out of range code byte
    code(8'h02, "R10");
    code(8'h07, "R10");
    chk("R10 v unchanged", 32'(vsync), 1);
    chk("R10 h unchanged", 32'(hsync), 1);
    code(8'h80, "R10");
    chk("R10 h unchanged 80", 32'(hsync), 1);

    // R7: pass-through
    step(1, 0, 1, 8'hFF, "R7");
    chk("R7 v low", 32'(vsync), 0);
    step(1, 0, 1, 8'h00, "R7"); step(1, 0, 1, 8'h00, "R7");
    step(1, 0, 1, 8'h02, "R7");
    chk("R7 sync code passed", 32'(out_data), 32'h02);
    chk("R7 no sof", 32'(vsync), 0);
    // partial in pass-through must not complete in decode mode
    step(1, 0, 1, 8'hFF, "R7"); step(1, 0, 1, 8'h00, "R7");
    step(1, 1, 1, 8'h00, "R7"); step(1, 1, 1, 8'h02, "R7");
    chk("R7 idle after bypass", 32'(vsync), 0);

    // R6: power-down
    code(8'h02, "R6");
    step(1, 1, 1, 8'hFF, "R6"); step(1, 1, 1, 8'h00, "R6");
    step(0, 1, 1, 8'hA5, "R6");
    chk("R6 off v", 32'(vsync), 0);
    chk("R6 off data", 32'(out_data), 0);
    chk("R6 off valid", 32'(out_valid), 0);
    step(0, 1, 1, 8'h00, "R6");
    step(1, 1, 1, 8'h00, "R6"); step(1, 1, 1, 8'h02, "R6");
    chk("R6 partial not resumed", 32'(vsync), 0);

    // random phase, checked every cycle against the model (R1, R8)
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 10;
      logic [7:0] d;
      bit en = ($urandom % 50) != 0;
      bit sel = ($urandom % 40) != 0;
      bit vld = ($urandom % 5) != 0;
      if (r < 3)      d = 8'hFF;
      else if (r < 6) d = 8'h00;
      else if (r < 8) d = 8'($urandom % 5);
      else            d = 8'($urandom);
      step(en, sel, vld, d, "R1 R8 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule